// File: doc/BRIEF.md
# Banked Window Address Decoder

This block sits on the bus of a small 8-bit processor with a 64 KB address space. Each access is sorted into one of five regions: local RAM, a sound-chip port range, the bank-register range, a range of miscellaneous peripheral ports, and a 32 KB window. The window is a view into a 24-bit host address space. For each access the block gives registered region selects, the local RAM offset, and the translated host address for window accesses. It also gives a strobe for the one sound port that accepts writes and a flag that marks reads that must return zero.

The base of the window is loaded one bit at a time. Each write to the bank-register range shifts the stored base down by one place and puts bit 0 of the write data in at the top. Only the upper nine bits of the 24-bit base are kept, so the window always starts on a 32 KB boundary. Software sets a full base with nine writes, starting with the least significant kept bit. The host bus cycle that follows a window access, and any arbitration with the host, are handled elsewhere.

Top module: `bank_window_decoder`

## Requirements
- R1: An access (rd_i or wr_i high at a clock edge) produces valid_o high for exactly the next cycle, together with its registered decode results. we_o is high when wr_i was high. With no access, valid_o stays low.
- R2: While valid_o is high, sel_o is one-hot with bit 0 = RAM (0x0000-0x3FFF), bit 1 = sound (0x4000-0x5FFF), bit 2 = bank register (0x6000-0x6FFF), bit 3 = misc ports (0x7000-0x7FFF), bit 4 = window (0x8000-0xFFFF). While valid_o is low, sel_o is zero.
- R3: A RAM access reports ram_addr_o equal to address bits 12:0, so 0x0000-0x1FFF and 0x2000-0x3FFF reach the same 8 KB. ram_addr_o is zero for other regions.
- R4: Only writes to 0x6000-0x60FF change the window base. Writes to 0x6100-0x6FFF and all reads leave it unchanged.
- R5: A bank write sets the new base to the old base shifted right by one, with data bit 0 in bit 23 and bits 14:0 cleared.
- R6: zero_rd_o is high with valid_o for reads of 0x6000-0x7FFF and low for all other accesses.
- R7: snd_wr_o is high with valid_o only for a write to 0x7F11. Reads of 0x7F11 and writes to other misc-port addresses leave it low.
- R8: A window access reports host_addr_o = base + address bits 14:0, using the base in effect before that access.
- R9: After reset the base is zero, so the window maps host 0x000000, and every output is zero.
- R10: host_addr_o is zero for accesses outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data (bit 0 feeds the base shifter) |
| valid_o | output | 1 | Decode results valid |
| we_o | output | 1 | Registered access is a write |
| sel_o | output | 5 | One-hot region select |
| ram_addr_o | output | 13 | Local RAM offset |
| host_addr_o | output | 24 | Translated host address |
| snd_wr_o | output | 1 | Write strobe for sound port 0x7F11 |
| zero_rd_o | output | 1 | Read must return zero |

## Verification
The bench loads the base with bit patterns that are not symmetric, so a shift in the wrong direction or data entering at the wrong end gives a window address that differs. Ten consecutive bank writes check that bit 15 is masked away rather than leaking into the window offset. Writes at 0x6100 and 0x6FFF check that the bank-write range is not decoded on the wide 4 KB region. RAM mirror pairs, the boundary addresses of each region, and reads and near-miss writes around 0x7F11 catch decoders that use the wrong address bits or give the sound strobe for reads.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int unsigned NREG = 5;
  typedef enum int unsigned {
    RG_RAM  = 0,
    RG_SND  = 1,
    RG_BANK = 2,
    RG_MISC = 3,
    RG_WIN  = 4
  } region_e;
  typedef logic [NREG-1:0] sel_t;
endpackage

// File: rtl/bw_decode.sv
module bw_decode
  import bw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BANK_HW  = 4,   // address bits above the byte that must be zero for a bank write
  parameter logic [ADDR_W-1:0] SND_PORT = 16'h7F11
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_t              sel_o,
  output logic              bank_hit_o,
  output logic              port_hit_o
);
  localparam int unsigned T = ADDR_W - 1;

  always_comb begin
    sel_o = '0;
    if (addr_i[T])          sel_o[RG_WIN]  = 1'b1;
    else if (!addr_i[T-1])  sel_o[RG_RAM]  = 1'b1;
    else if (!addr_i[T-2])  sel_o[RG_SND]  = 1'b1;
    else if (!addr_i[T-3])  sel_o[RG_BANK] = 1'b1;
    else                    sel_o[RG_MISC] = 1'b1;
  end

  assign bank_hit_o = sel_o[RG_BANK] && (addr_i[T-4 -: BANK_HW] == '0);
  assign port_hit_o = (addr_i == SND_PORT);
endmodule

// File: rtl/bw_bank.sv
module bw_bank #(
  parameter int unsigned HOST_W = 24,
  parameter int unsigned WIN_AW = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HOST_W-1:0] base_o
);
  localparam int unsigned KEEP_W = HOST_W - WIN_AW;

  logic [KEEP_W-1:0] keep_q;

  // Bit WIN_AW shifts into the masked field and is lost.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      keep_q <= '0;
    else if (shift_i) keep_q <= {bit_i, keep_q[KEEP_W-1:1]};
  end

  assign base_o = {keep_q, {WIN_AW{1'b0}}};

  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(keep_q)) else $error("bank changed without write"); // R4
  AST_BANK_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (keep_q[KEEP_W-1] == $past(bit_i)) &&
                (keep_q[KEEP_W-2:0] == $past(keep_q[KEEP_W-1:1]))) else $error("bad shift"); // R5
endmodule

// File: rtl/bank_window_decoder.sv
module bank_window_decoder
  import bw_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned HOST_W = 24,
  parameter int unsigned RAM_AW = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              valid_o,
  output logic              we_o,
  output logic [NREG-1:0]   sel_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [HOST_W-1:0] host_addr_o,
  output logic              snd_wr_o,
  output logic              zero_rd_o
);
  localparam int unsigned WIN_AW = ADDR_W - 1;

  sel_t              sel_d;
  logic              bank_hit, port_hit, access;
  logic [HOST_W-1:0] base;

  assign access = rd_i | wr_i;

  bw_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i     (addr_i),
    .sel_o      (sel_d),
    .bank_hit_o (bank_hit),
    .port_hit_o (port_hit)
  );

  bw_bank #(.HOST_W(HOST_W), .WIN_AW(WIN_AW)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (wr_i && bank_hit),
    .bit_i   (wdata_i[0]),
    .base_o  (base)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      we_o        <= 1'b0;
      sel_o       <= '0;
      ram_addr_o  <= '0;
      host_addr_o <= '0;
      snd_wr_o    <= 1'b0;
      zero_rd_o   <= 1'b0;
    end else begin
      valid_o     <= access;
      we_o        <= access && wr_i;
      sel_o       <= access ? sel_d : '0;
      ram_addr_o  <= (access && sel_d[RG_RAM]) ? addr_i[RAM_AW-1:0] : '0;
      host_addr_o <= (access && sel_d[RG_WIN])
                     ? base + HOST_W'(addr_i[WIN_AW-1:0]) : '0;
      snd_wr_o    <= wr_i && port_hit;
      zero_rd_o   <= !wr_i && rd_i && (sel_d[RG_BANK] || sel_d[RG_MISC]);
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rd_i || wr_i)) else $error("valid without access"); // R1
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(sel_o) == 1) else $error("select not one-hot"); // R2
  AST_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> sel_o == '0) else $error("select while idle"); // R2
  AST_SND_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snd_wr_o |-> valid_o && we_o && sel_o[RG_MISC]) else $error("stray sound strobe"); // R7
  AST_ZERO_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_rd_o |-> valid_o && !we_o) else $error("zero flag on write"); // R6
  AST_HOST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o[RG_WIN] |-> host_addr_o == '0) else $error("host addr outside window"); // R10
endmodule

// File: tb/bank_window_decoder_tb.sv
module bank_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic        valid, we, snd_wr, zero_rd;
  logic [4:0]  sel;
  logic [12:0] ram_addr;
  logic [23:0] host_addr;

  int checks = 0;
  int errors = 0;
  logic [23:0] bm = '0;  // model of window base

  always #10 clk = ~clk;

  bank_window_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .valid_o(valid), .we_o(we), .sel_o(sel), .ram_addr_o(ram_addr),
    .host_addr_o(host_addr), .snd_wr_o(snd_wr), .zero_rd_o(zero_rd)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one access; outputs sampled at the following negedge
  task automatic acc(input logic [15:0] a, input bit w, input logic [7:0] d);
    @(negedge clk);
    addr = a; rd = !w; wr = w; wdata = d;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    if (w && a >= 16'h6000 && a <= 16'h60FF) bm = {d[0], bm[23:1]} & 24'hFF8000;
  endtask

  task automatic t_reset;
    chk(valid == 0 && sel == 0 && host_addr == 0 && ram_addr == 0 && !snd_wr && !zero_rd,
        "R9 outputs at reset", {valid, sel, snd_wr, zero_rd}, 0);
    acc(16'h8000, 0, 0);
    chk(host_addr == 24'h0, "R9 base zero after reset", host_addr, 0);
    chk(valid && !we, "R1 valid read", {valid, we}, 2);
    @(negedge clk);
    chk(!valid && sel == 0, "R1 valid single cycle", {valid, sel}, 0);
  endtask

  task automatic t_ram;
    acc(16'h0123, 0, 0);
    chk(sel == 5'b00001 && ram_addr == 13'h0123, "R3 ram low", {sel, ram_addr}, {5'b1, 13'h123});
    acc(16'h2123, 1, 8'h55);
    chk(sel == 5'b00001 && ram_addr == 13'h0123 && we, "R3 ram mirror", ram_addr, 13'h123);
    chk(host_addr == 0, "R10 host zero on ram", host_addr, 0);
    acc(16'h3FFF, 0, 0);
    chk(ram_addr == 13'h1FFF && sel == 5'b00001, "R2 ram top", ram_addr, 13'h1FFF);
  endtask

  task automatic t_regions;
    acc(16'h4000, 0, 0); chk(sel == 5'b00010, "R2 sound low", sel, 5'b00010);
    acc(16'h5FFF, 1, 0); chk(sel == 5'b00010 && ram_addr == 0, "R2 sound top", sel, 5'b00010);
    acc(16'h6FFF, 0, 0); chk(sel == 5'b00100, "R2 bank region", sel, 5'b00100);
    acc(16'h7000, 0, 0); chk(sel == 5'b01000, "R2 misc region", sel, 5'b01000);
    acc(16'hFFFF, 0, 0); chk(sel == 5'b10000, "R2 window top", sel, 5'b10000);
  endtask

  task automatic t_zero;
    acc(16'h6050, 0, 0); chk(zero_rd, "R6 bank read zero", zero_rd, 1);
    acc(16'h7123, 0, 0); chk(zero_rd, "R6 misc read zero", zero_rd, 1);
    acc(16'h7123, 1, 0); chk(!zero_rd, "R6 misc write no flag", zero_rd, 0);
    acc(16'h4000, 0, 0); chk(!zero_rd, "R6 sound read no flag", zero_rd, 0);
  endtask

  task automatic t_sound;
    acc(16'h7F11, 1, 8'h9F); chk(snd_wr && sel == 5'b01000, "R7 port write", snd_wr, 1);
    acc(16'h7F11, 0, 0);     chk(!snd_wr, "R7 port read", snd_wr, 0);
    acc(16'h7F10, 1, 0);     chk(!snd_wr, "R7 neighbour write", snd_wr, 0);
    acc(16'h4011, 1, 0);     chk(!snd_wr, "R7 sound region write", snd_wr, 0);
  endtask

  task automatic t_bank;
    logic [8:0] pat = 9'b1_0110_0101;
    for (int i = 0; i < 9; i++) acc(16'h6000 + 16'(i), 1, {7'b0, pat[i]});
    acc(16'h8000, 0, 0);
    chk(host_addr == bm, "R5 nine-bit load", host_addr, bm);
    chk(bm == {pat, 15'h0}, "R5 model base", bm, {pat, 15'h0});
    acc(16'hABCD, 0, 0);
    chk(host_addr == bm + 24'h2BCD, "R8 window offset", host_addr, bm + 24'h2BCD);
    acc(16'h60FF, 1, 8'hFE);  // bit0 = 0
    acc(16'h60FF, 1, 8'h01);
    acc(16'hFFFF, 1, 0);
    chk(host_addr == bm + 24'h7FFF, "R5 bit15 masked", host_addr, bm + 24'h7FFF);
    acc(16'h6100, 1, 8'h01);
    acc(16'h6FFF, 1, 8'h01);
    acc(16'h6000, 0, 8'h01);
    acc(16'h8001, 0, 0);
    chk(host_addr == bm + 24'h1, "R4 ignored bank writes", host_addr, bm + 24'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ram();
    t_regions();
    t_zero();
    t_sound();
    t_bank();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule